// File: doc/BRIEF.md
# Oldest-First Integer Issue Queue

This block is the issue stage for the integer side of one thread. It holds up to 40 waiting micro-ops in fixed slots. Each op carries two source tags with ready flags, a port class, an opaque payload and a parity bit made by the dispatcher. Result broadcasts arrive on four wakeup tag buses. An entry whose source tag matches a broadcast marks that source ready. Once both sources are ready, the entry competes for one of two ports of its class: two ports serve ALU ops and two serve address-generation ops. Up to four ops leave per cycle. Operand fetch and execution happen further down the pipe.

Slots never shift. An issued slot becomes free and is reused by a later dispatch. A separate age matrix records which valid entry is the oldest. If that entry is ready, it takes the first port of its class. Every other ready op is chosen by lowest slot number, whatever its age. Dispatch places up to four ops per cycle into the lowest free slots. It is refused as a whole while fewer than four slots are free. Parity is checked on each op as it issues.

Top module: `sched_iq`

## Requirements
- R1: During and right after reset, no issue port is valid, `disp_ready` is 1 and `par_err` is 0.
- R2: Accepted dispatch lanes with `disp_valid` set are written in ascending lane order into the lowest-numbered free slots. `iss_slot` reports the slot an op occupied.
- R3: An entry may issue only when both source ready flags are set. An issued entry issues exactly once, and its slot is free after the clock edge on which it was visible on an issue port.
- R4: A wakeup bus with `wake_valid` set whose tag equals a source tag sets that source's ready flag at the clock edge. This applies both to stored entries and to ops being dispatched at that same edge. The op can issue in the following cycle.
- R5: Class encoding: `disp_cls` = 0 is ALU and issues only on ports 0 and 1; `disp_cls` = 1 is address generation and issues only on ports 2 and 3. Up to four ops issue in one cycle.
- R6: When the single oldest valid entry is ready, it is granted the first port of its class (port 0 for ALU, port 2 for address generation). Within one dispatch cycle, lower lanes count as older.
- R7: All other grants go to the lowest-numbered ready slot of the class, regardless of age. The second port of a class is used only when its first port is used.
- R8: `disp_ready` is 1 exactly when at least four slots are free. While it is 0, dispatch lanes are ignored.
- R9: `disp_par` is even parity: the XOR of both source tags, the class bit, the payload and `disp_par` is zero. `par_err` is 1 in a cycle exactly when some op shown on an issue port has stored fields that break this rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 4 | Per-lane dispatch request |
| disp_src0 | input | 28 | First source tag per lane (7 bits each, lane 0 in low bits) |
| disp_src0_rdy | input | 4 | First source already ready, per lane |
| disp_src1 | input | 28 | Second source tag per lane |
| disp_src1_rdy | input | 4 | Second source already ready, per lane |
| disp_cls | input | 4 | Port class per lane (0 ALU, 1 address generation) |
| disp_payload | input | 32 | Opaque op payload per lane (8 bits each) |
| disp_par | input | 4 | Even parity bit per lane |
| disp_ready | output | 1 | At least four free slots; dispatch accepted this cycle |
| wake_valid | input | 4 | Per-bus wakeup strobe |
| wake_tag | input | 28 | Wakeup tag per bus (7 bits each) |
| iss_valid | output | 4 | Per-port issue valid |
| iss_slot | output | 24 | Slot of the issued op per port (6 bits each) |
| iss_payload | output | 32 | Payload of the issued op per port |
| par_err | output | 1 | Parity mismatch on an op issuing this cycle |

## Verification
Dispatch and wakeup can fall on the same edge. A new op can carry the very tag that is being broadcast, and a stored entry waiting on that tag must be woken in that same cycle. The bench provokes this by dispatching an op whose source tag is on a wakeup bus at that edge, while an older entry waits on the same tag. The scoreboard then requires both ops to issue in the next cycle on ports 0 and 1, in age order. A second overlap is issue together with oldest-first arbitration: a young low slot and an old high slot become ready together, and the expected port assignment is predicted from age and slot order.

// File: rtl/sched_pkg.sv
// Shared types for the issue queue.
// Assumes: two port classes, class code is one bit wide.
package sched_pkg;
    typedef enum logic {
        CLS_ALU = 1'b0,
        CLS_AGU = 1'b1
    } op_cls_e;

    localparam int unsigned NUM_CLASSES = 2;
endpackage

// File: rtl/sched_alloc.sv
// Free-slot allocator: hands each requesting lane, in lane order, the
// lowest free slot not already taken by a lower lane, and reports
// whether enough slots are free to accept a full dispatch group.
// Assumes: caller gates the picks with the room flag.
module sched_alloc #(
    parameter int unsigned ENTRIES = 40,
    parameter int unsigned LANES   = 4
) (
    input  logic [ENTRIES-1:0]            free_mask,
    input  logic [LANES-1:0]              req,
    output logic [LANES-1:0][ENTRIES-1:0] pick_oh,
    output logic                          room
);
    localparam int unsigned CNT_W = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0] avail;
    logic [CNT_W-1:0]   free_cnt;

    // Lowest-set-bit pick per lane, removing each pick from the pool.
    always_comb begin
        avail = free_mask;
        for (int k = 0; k < int'(LANES); k++) begin
            pick_oh[k] = '0;
            if (req[k]) begin
                pick_oh[k] = avail & (~avail + ENTRIES'(1));
                avail      = avail & ~pick_oh[k];
            end
        end
    end

    // Count free slots and compare with the dispatch width.
    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            free_cnt = free_cnt + CNT_W'(free_mask[i]);
        end
        room = (free_cnt >= CNT_W'(LANES));
    end
endmodule

// File: rtl/sched_age.sv
// Age matrix: row i holds a bit per slot that is older than slot i.
// A newly written row copies the current valid mask plus slots written
// by lower lanes in the same cycle; the new slot's column is cleared in
// every other row. The oldest valid entry is the one whose row, masked
// by valid, is empty.
// Assumes: wr_oh lanes are one-hot or zero, disjoint, and hit free slots.
module sched_age #(
    parameter int unsigned ENTRIES = 40,
    parameter int unsigned LANES   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ENTRIES-1:0]            valid_q,
    input  logic [LANES-1:0][ENTRIES-1:0] wr_oh,
    output logic [ENTRIES-1:0]            oldest_oh
);
    logic [ENTRIES-1:0]            older_q [ENTRIES];
    logic [ENTRIES-1:0]            older_d [ENTRIES];
    logic [LANES-1:0][ENTRIES-1:0] lane_row;
    logic [ENTRIES-1:0]            acc_mask;
    logic [ENTRIES-1:0]            wr_any;

    // Build each lane's age row from valid slots and lower lanes.
    always_comb begin
        acc_mask = valid_q;
        wr_any   = '0;
        for (int k = 0; k < int'(LANES); k++) begin
            lane_row[k] = acc_mask;
            acc_mask    = acc_mask | wr_oh[k];
            wr_any      = wr_any | wr_oh[k];
        end
    end

    // Next row contents: load on write, else drop the new slots' columns.
    always_comb begin
        for (int i = 0; i < int'(ENTRIES); i++) begin
            older_d[i] = older_q[i] & ~wr_any;
            for (int k = 0; k < int'(LANES); k++) begin
                if (wr_oh[k][i]) begin
                    older_d[i] = lane_row[k];
                end
            end
        end
    end

    // Register the matrix.
    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (!rst_n) begin
                older_q[i] <= '0;
            end else begin
                older_q[i] <= older_d[i];
            end
        end
    end

    // Oldest = valid entry with no valid entry older than it.
    always_comb begin
        for (int i = 0; i < int'(ENTRIES); i++) begin
            oldest_oh[i] = valid_q[i] && ((older_q[i] & valid_q) == '0);
        end
    end
endmodule

// File: rtl/sched_pick.sv
// Per-class port picker: the first port takes the oldest entry when it
// is a candidate, otherwise the lowest candidate slot; later ports take
// the lowest remaining candidate slot.
// Assumes: oldest_oh is one-hot or zero.
module sched_pick #(
    parameter int unsigned ENTRIES = 40,
    parameter int unsigned PORTS   = 2
) (
    input  logic [ENTRIES-1:0]            cand,
    input  logic [ENTRIES-1:0]            oldest_oh,
    output logic [PORTS-1:0][ENTRIES-1:0] grant_oh
);
    logic [ENTRIES-1:0] rem;
    logic [ENTRIES-1:0] old_cand;

    // Serial port assignment over the remaining candidates.
    always_comb begin
        rem      = cand;
        old_cand = cand & oldest_oh;
        for (int p = 0; p < int'(PORTS); p++) begin
            if (p == 0 && old_cand != '0) begin
                grant_oh[p] = old_cand;
            end else begin
                grant_oh[p] = rem & (~rem + ENTRIES'(1));
            end
            rem = rem & ~grant_oh[p];
        end
    end
endmodule

// File: rtl/sched_iq.sv
// Unified non-collapsing issue queue for one thread's integer ops.
// Holds ops in fixed slots, wakes sources from broadcast tags, issues up
// to PORTS_PER_CLASS ops per class per cycle with oldest-first priority
// for the single oldest entry and slot order for the rest, and checks
// even parity on issue.
// Assumes: issue outputs are consumed unconditionally every cycle.
module sched_iq
    import sched_pkg::*;
#(
    parameter int unsigned ENTRIES         = 40,
    parameter int unsigned LANES           = 4,
    parameter int unsigned WAKES           = 4,
    parameter int unsigned PORTS_PER_CLASS = 2,
    parameter int unsigned TAG_W           = 7,
    parameter int unsigned PAY_W           = 8,
    localparam int unsigned PORTS          = NUM_CLASSES * PORTS_PER_CLASS,
    localparam int unsigned SLOT_W         = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         disp_valid,
    input  logic [LANES*TAG_W-1:0]   disp_src0,
    input  logic [LANES-1:0]         disp_src0_rdy,
    input  logic [LANES*TAG_W-1:0]   disp_src1,
    input  logic [LANES-1:0]         disp_src1_rdy,
    input  logic [LANES-1:0]         disp_cls,
    input  logic [LANES*PAY_W-1:0]   disp_payload,
    input  logic [LANES-1:0]         disp_par,
    output logic                     disp_ready,
    input  logic [WAKES-1:0]         wake_valid,
    input  logic [WAKES*TAG_W-1:0]   wake_tag,
    output logic [PORTS-1:0]         iss_valid,
    output logic [PORTS*SLOT_W-1:0]  iss_slot,
    output logic [PORTS*PAY_W-1:0]   iss_payload,
    output logic                     par_err
);
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    // Entry storage.
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] rdy0_q;
    logic [ENTRIES-1:0] rdy1_q;
    logic [ENTRIES-1:0] par_q;
    op_cls_e            cls_q  [ENTRIES];
    logic [TAG_W-1:0]   src0_q [ENTRIES];
    logic [TAG_W-1:0]   src1_q [ENTRIES];
    logic [PAY_W-1:0]   pay_q  [ENTRIES];

    // Allocation and selection nets.
    logic [LANES-1:0][ENTRIES-1:0] pick_oh;
    logic [LANES-1:0][ENTRIES-1:0] wr_oh;
    logic [ENTRIES-1:0]            wr_any;
    logic [LANE_W-1:0]             lane_sel [ENTRIES];
    logic [ENTRIES-1:0]            hit0;
    logic [ENTRIES-1:0]            hit1;
    logic [LANES-1:0]              lane_rdy0;
    logic [LANES-1:0]              lane_rdy1;
    logic [ENTRIES-1:0]            oldest_oh;
    logic [NUM_CLASSES-1:0][ENTRIES-1:0]                      cand;
    logic [NUM_CLASSES-1:0][PORTS_PER_CLASS-1:0][ENTRIES-1:0] grant;
    logic [ENTRIES-1:0]            issued;
    logic [ENTRIES-1:0]            bad_par;

    // True when any valid wakeup bus carries the given tag.
    function automatic logic tag_hit(
        input logic [TAG_W-1:0]       t,
        input logic [WAKES-1:0]       wv,
        input logic [WAKES*TAG_W-1:0] wt
    );
        logic h;
        h = 1'b0;
        for (int w = 0; w < int'(WAKES); w++) begin
            if (wv[w] && wt[w*TAG_W +: TAG_W] == t) begin
                h = 1'b1;
            end
        end
        return h;
    endfunction

    sched_alloc #(.ENTRIES(ENTRIES), .LANES(LANES)) u_alloc (
        .free_mask (~valid_q),
        .req       (disp_valid),
        .pick_oh   (pick_oh),
        .room      (disp_ready)
    );

    // Gate picks with room and map each written slot to its lane.
    always_comb begin
        for (int k = 0; k < int'(LANES); k++) begin
            wr_oh[k] = disp_ready ? pick_oh[k] : '0;
        end
        for (int i = 0; i < int'(ENTRIES); i++) begin
            wr_any[i]   = 1'b0;
            lane_sel[i] = '0;
            for (int k = 0; k < int'(LANES); k++) begin
                if (wr_oh[k][i]) begin
                    wr_any[i]   = 1'b1;
                    lane_sel[i] = LANE_W'(k);
                end
            end
        end
    end

    // Tag match for stored entries and for lanes being dispatched.
    always_comb begin
        for (int i = 0; i < int'(ENTRIES); i++) begin
            hit0[i] = tag_hit(src0_q[i], wake_valid, wake_tag);
            hit1[i] = tag_hit(src1_q[i], wake_valid, wake_tag);
        end
        for (int k = 0; k < int'(LANES); k++) begin
            lane_rdy0[k] = disp_src0_rdy[k] |
                           tag_hit(disp_src0[k*TAG_W +: TAG_W], wake_valid, wake_tag);
            lane_rdy1[k] = disp_src1_rdy[k] |
                           tag_hit(disp_src1[k*TAG_W +: TAG_W], wake_valid, wake_tag);
        end
    end

    sched_age #(.ENTRIES(ENTRIES), .LANES(LANES)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_q   (valid_q),
        .wr_oh     (wr_oh),
        .oldest_oh (oldest_oh)
    );

    // Ready candidates per class.
    always_comb begin
        for (int c = 0; c < int'(NUM_CLASSES); c++) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                cand[c][i] = valid_q[i] && rdy0_q[i] && rdy1_q[i] &&
                             (cls_q[i] == op_cls_e'(c));
            end
        end
    end

    for (genvar c = 0; c < int'(NUM_CLASSES); c++) begin : g_class
        sched_pick #(.ENTRIES(ENTRIES), .PORTS(PORTS_PER_CLASS)) u_pick (
            .cand      (cand[c]),
            .oldest_oh (oldest_oh),
            .grant_oh  (grant[c])
        );
    end

    // Issue muxing, issued-slot mask and parity check.
    always_comb begin
        iss_valid   = '0;
        iss_slot    = '0;
        iss_payload = '0;
        issued      = '0;
        for (int c = 0; c < int'(NUM_CLASSES); c++) begin
            for (int q = 0; q < int'(PORTS_PER_CLASS); q++) begin
                for (int i = 0; i < int'(ENTRIES); i++) begin
                    if (grant[c][q][i]) begin
                        iss_valid[c*PORTS_PER_CLASS + q] = 1'b1;
                        iss_slot[(c*PORTS_PER_CLASS + q)*SLOT_W +: SLOT_W] =
                            iss_slot[(c*PORTS_PER_CLASS + q)*SLOT_W +: SLOT_W] | SLOT_W'(i);
                        iss_payload[(c*PORTS_PER_CLASS + q)*PAY_W +: PAY_W] =
                            iss_payload[(c*PORTS_PER_CLASS + q)*PAY_W +: PAY_W] | pay_q[i];
                        issued[i] = 1'b1;
                    end
                end
            end
        end
        for (int i = 0; i < int'(ENTRIES); i++) begin
            bad_par[i] = (^{src0_q[i], src1_q[i], cls_q[i], pay_q[i]}) ^ par_q[i];
        end
        par_err = |(bad_par & issued);
    end

    // Valid and ready state: load on dispatch, clear on issue, wake on match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rdy0_q  <= '0;
            rdy1_q  <= '0;
        end else begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                if (wr_any[i]) begin
                    valid_q[i] <= 1'b1;
                    rdy0_q[i]  <= lane_rdy0[lane_sel[i]];
                    rdy1_q[i]  <= lane_rdy1[lane_sel[i]];
                end else if (issued[i]) begin
                    valid_q[i] <= 1'b0;
                    rdy0_q[i]  <= 1'b0;
                    rdy1_q[i]  <= 1'b0;
                end else begin
                    rdy0_q[i]  <= rdy0_q[i] | hit0[i];
                    rdy1_q[i]  <= rdy1_q[i] | hit1[i];
                end
            end
        end
    end

    // Entry payload fields, written only on dispatch.
    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (wr_any[i]) begin
                src0_q[i] <= disp_src0[int'(lane_sel[i])*TAG_W +: TAG_W];
                src1_q[i] <= disp_src1[int'(lane_sel[i])*TAG_W +: TAG_W];
                cls_q[i]  <= op_cls_e'(disp_cls[lane_sel[i]]);
                pay_q[i]  <= disp_payload[int'(lane_sel[i])*PAY_W +: PAY_W];
                par_q[i]  <= disp_par[lane_sel[i]];
            end
        end
    end
endmodule

// File: rtl/sched_iq_chk.sv
// Port-level properties of the issue queue, bound onto every instance.
// Assumes: ports are grouped per class, PPC ports per class.
module sched_iq_chk #(
    parameter int unsigned PORTS  = 4,
    parameter int unsigned PPC    = 2,
    parameter int unsigned SLOT_W = 6,
    parameter int unsigned LANES  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES-1:0]        disp_valid,
    input logic                    disp_ready,
    input logic [PORTS-1:0]        iss_valid,
    input logic [PORTS*SLOT_W-1:0] iss_slot,
    input logic                    par_err
);
    // R1: the first cycle out of reset is idle and open for dispatch.
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (iss_valid == '0 && disp_ready && !par_err));

    // R8: a full queue stays closed while nothing issues.
    p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready && iss_valid == '0) |=> !disp_ready);

    // R9: a parity error only accompanies an issue.
    p_perr_with_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (iss_valid != '0));

    for (genvar p = 0; p < int'(PORTS); p++) begin : g_port
        // R3: a slot shown on a port is gone next cycle unless refilled.
        p_no_reissue_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid[p] && !(disp_ready && disp_valid != '0)) |=>
            !(iss_valid[p] && iss_slot[p*SLOT_W +: SLOT_W] ==
              $past(iss_slot[p*SLOT_W +: SLOT_W])));
        for (genvar q = p + 1; q < int'(PORTS); q++) begin : g_pair
            // R2: no slot is driven on two ports at once.
            p_distinct_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid[p] && iss_valid[q]) |->
                (iss_slot[p*SLOT_W +: SLOT_W] != iss_slot[q*SLOT_W +: SLOT_W]));
        end
    end

    for (genvar c = 0; c < int'(PORTS / PPC); c++) begin : g_cls
        for (genvar q = 1; q < int'(PPC); q++) begin : g_fill
            // R7: later ports of a class fill only after earlier ones.
            p_fill_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[c*PPC + q] |-> iss_valid[c*PPC + q - 1]);
        end
    end
endmodule

bind sched_iq sched_iq_chk #(
    .PORTS  (PORTS),
    .PPC    (PORTS_PER_CLASS),
    .SLOT_W (SLOT_W),
    .LANES  (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .iss_valid  (iss_valid),
    .iss_slot   (iss_slot),
    .par_err    (par_err)
);

// File: tb/sched_iq_tb.sv
// Scoreboard bench for sched_iq: driver tasks push expected issues into
// a queue; a monitor pops and compares them as ops leave the ports.
module sched_iq_tb;
    localparam int LANES = 4;
    localparam int WAKES = 4;
    localparam int PORTS = 4;
    localparam int TAG_W = 7;
    localparam int PAY_W = 8;
    localparam int SLOT_W = 6;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [LANES-1:0]        disp_valid;
    logic [LANES*TAG_W-1:0]  disp_src0;
    logic [LANES-1:0]        disp_src0_rdy;
    logic [LANES*TAG_W-1:0]  disp_src1;
    logic [LANES-1:0]        disp_src1_rdy;
    logic [LANES-1:0]        disp_cls;
    logic [LANES*PAY_W-1:0]  disp_payload;
    logic [LANES-1:0]        disp_par;
    logic                    disp_ready;
    logic [WAKES-1:0]        wake_valid;
    logic [WAKES*TAG_W-1:0]  wake_tag;
    logic [PORTS-1:0]        iss_valid;
    logic [PORTS*SLOT_W-1:0] iss_slot;
    logic [PORTS*PAY_W-1:0]  iss_payload;
    logic                    par_err;

    typedef struct {
        int    port;
        int    slot;
        int    pay;
        bit    perr;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #5 clk = ~clk;

    sched_iq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .disp_valid    (disp_valid),
        .disp_src0     (disp_src0),
        .disp_src0_rdy (disp_src0_rdy),
        .disp_src1     (disp_src1),
        .disp_src1_rdy (disp_src1_rdy),
        .disp_cls      (disp_cls),
        .disp_payload  (disp_payload),
        .disp_par      (disp_par),
        .disp_ready    (disp_ready),
        .wake_valid    (wake_valid),
        .wake_tag      (wake_tag),
        .iss_valid     (iss_valid),
        .iss_slot      (iss_slot),
        .iss_payload   (iss_payload),
        .par_err       (par_err)
    );

    task automatic clear_in();
        disp_valid = '0; disp_src0 = '0; disp_src0_rdy = '0;
        disp_src1 = '0;  disp_src1_rdy = '0; disp_cls = '0;
        disp_payload = '0; disp_par = '0;
        wake_valid = '0; wake_tag = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_lane(input int k, input int s0, input bit r0, input int s1,
                            input bit r1, input bit cls, input int pay, input bit badp);
        logic [TAG_W-1:0] t0, t1;
        logic [PAY_W-1:0] pw;
        t0 = TAG_W'(s0); t1 = TAG_W'(s1); pw = PAY_W'(pay);
        disp_valid[k]                  = 1'b1;
        disp_src0[k*TAG_W +: TAG_W]    = t0;
        disp_src0_rdy[k]               = r0;
        disp_src1[k*TAG_W +: TAG_W]    = t1;
        disp_src1_rdy[k]               = r1;
        disp_cls[k]                    = cls;
        disp_payload[k*PAY_W +: PAY_W] = pw;
        disp_par[k]                    = (^{t0, t1, cls, pw}) ^ badp;
    endtask

    task automatic wake(input int w, input int tag);
        wake_valid[w]              = 1'b1;
        wake_tag[w*TAG_W +: TAG_W] = TAG_W'(tag);
    endtask

    task automatic push(input int port, input int slot, input int pay,
                        input bit perr, input string req);
        exp_t e;
        e.port = port; e.slot = slot; e.pay = pay; e.perr = perr; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic check_bit(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    // Monitor: pop one expected item per valid port, in port order.
    always @(negedge clk) begin
        bit   any;
        bit   eperr;
        exp_t e;
        any = 1'b0;
        eperr = 1'b0;
        if (rst_n === 1'b1 && !done) begin
            for (int p = 0; p < PORTS; p++) begin
                if (iss_valid[p]) begin
                    any = 1'b1;
                    n_checks++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R3: unexpected issue port %0d slot %0d payload %0h, expected none",
                                 p, iss_slot[p*SLOT_W +: SLOT_W], iss_payload[p*PAY_W +: PAY_W]);
                    end else begin
                        e = exp_q.pop_front();
                        eperr = eperr | e.perr;
                        if (p != e.port || int'(iss_slot[p*SLOT_W +: SLOT_W]) != e.slot ||
                            int'(iss_payload[p*PAY_W +: PAY_W]) != e.pay) begin
                            n_fail++;
                            $display("FAIL %s: actual port %0d slot %0d payload %0h, expected port %0d slot %0d payload %0h",
                                     e.req, p, iss_slot[p*SLOT_W +: SLOT_W],
                                     iss_payload[p*PAY_W +: PAY_W], e.port, e.slot, e.pay);
                        end
                    end
                end
            end
            if (any || par_err !== 1'b0) begin
                n_checks++;
                if (par_err !== eperr) begin
                    n_fail++;
                    $display("FAIL R9: par_err actual %0b expected %0b", par_err, eperr);
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        clear_in();
        rst_n = 1'b0;
        repeat (3) tick();
        // R1: reset state while in reset and after release.
        check_bit(disp_ready, 1'b1, "R1 disp_ready in reset");
        check_bit(|iss_valid, 1'b0, "R1 iss_valid in reset");
        rst_n = 1'b1;
        tick();
        check_bit(disp_ready, 1'b1, "R1 disp_ready after reset");
        check_bit(|iss_valid, 1'b0, "R1 iss_valid after reset");
        check_bit(par_err, 1'b0, "R1 par_err after reset");

        // R2/R5/R6: sparse lanes pack into slots 0..2; classes to their ports.
        set_lane(0, 1, 1, 1, 1, 1'b0, 'h11, 1'b0);
        set_lane(2, 1, 1, 1, 1, 1'b1, 'h12, 1'b0);
        set_lane(3, 1, 1, 1, 1, 1'b0, 'h13, 1'b0);
        push(0, 0, 'h11, 1'b0, "R6");
        push(1, 2, 'h13, 1'b0, "R2");
        push(2, 1, 'h12, 1'b0, "R5");
        tick(); clear_in(); tick(); tick();

        // R4: a stored entry woken on wake bus 3.
        set_lane(0, 5, 1'b0, 9, 1'b1, 1'b0, 'h21, 1'b0);
        tick(); clear_in(); tick(); tick();
        wake(3, 5);
        push(0, 0, 'h21, 1'b0, "R4");
        tick(); clear_in(); tick(); tick();

        // R3: both sources are needed before issue.
        set_lane(0, 6, 1'b0, 7, 1'b0, 1'b0, 'h22, 1'b0);
        tick(); clear_in();
        wake(0, 6);
        tick(); clear_in(); tick(); tick();
        wake(1, 7);
        push(0, 0, 'h22, 1'b0, "R3");
        tick(); clear_in(); tick(); tick();

        // R6/R7: old entry in slot 1 beats young slot 0; slot order beats age after it.
        set_lane(0, 20, 1'b0, 1, 1'b1, 1'b0, 'h31, 1'b0);
        set_lane(1, 21, 1'b0, 1, 1'b1, 1'b0, 'h32, 1'b0);
        tick(); clear_in();
        set_lane(0, 22, 1'b0, 1, 1'b1, 1'b0, 'h33, 1'b0);
        tick(); clear_in();
        wake(0, 20);
        push(0, 0, 'h31, 1'b0, "R6");
        tick(); clear_in();
        tick();
        set_lane(0, 23, 1'b0, 1, 1'b1, 1'b0, 'h34, 1'b0);
        tick(); clear_in();
        wake(0, 21); wake(1, 22); wake(2, 23);
        push(0, 1, 'h32, 1'b0, "R6");
        push(1, 0, 'h34, 1'b0, "R7");
        push(0, 2, 'h33, 1'b0, "R7");
        tick(); clear_in(); tick(); tick(); tick();

        // R7/R5: oldest not ready, so slot order; AGU ops use ports 2 and 3.
        set_lane(0, 30, 1'b0, 1, 1'b1, 1'b0, 'h41, 1'b0);
        set_lane(1, 1, 1'b1, 1, 1'b1, 1'b0, 'h42, 1'b0);
        set_lane(2, 1, 1'b1, 1, 1'b1, 1'b1, 'h43, 1'b0);
        set_lane(3, 1, 1'b1, 1, 1'b1, 1'b1, 'h44, 1'b0);
        push(0, 1, 'h42, 1'b0, "R7");
        push(2, 2, 'h43, 1'b0, "R5");
        push(3, 3, 'h44, 1'b0, "R5");
        tick(); clear_in(); tick();
        wake(1, 30);
        push(0, 0, 'h41, 1'b0, "R4");
        tick(); clear_in(); tick(); tick();

        // R5: four ops in one cycle, two per class.
        set_lane(0, 1, 1'b1, 1, 1'b1, 1'b0, 'h51, 1'b0);
        set_lane(1, 1, 1'b1, 1, 1'b1, 1'b1, 'h52, 1'b0);
        set_lane(2, 1, 1'b1, 1, 1'b1, 1'b0, 'h53, 1'b0);
        set_lane(3, 1, 1'b1, 1, 1'b1, 1'b1, 'h54, 1'b0);
        push(0, 0, 'h51, 1'b0, "R5");
        push(1, 2, 'h53, 1'b0, "R5");
        push(2, 1, 'h52, 1'b0, "R5");
        push(3, 3, 'h54, 1'b0, "R5");
        tick(); clear_in(); tick(); tick();

        // R4: dispatch and wakeup of the same tag on one edge, with an older waiter.
        set_lane(0, 41, 1'b0, 1, 1'b1, 1'b0, 'h62, 1'b0);
        tick(); clear_in(); tick();
        set_lane(0, 41, 1'b0, 1, 1'b1, 1'b0, 'h63, 1'b0);
        wake(2, 41);
        push(0, 0, 'h62, 1'b0, "R4");
        push(1, 1, 'h63, 1'b0, "R4");
        tick(); clear_in(); tick(); tick();

        // R9: corrupted parity flags an error; clean parity does not.
        set_lane(0, 1, 1'b1, 1, 1'b1, 1'b0, 'h71, 1'b1);
        set_lane(1, 1, 1'b1, 1, 1'b1, 1'b1, 'h72, 1'b0);
        push(0, 0, 'h71, 1'b1, "R9");
        push(2, 1, 'h72, 1'b0, "R9");
        tick(); clear_in(); tick(); tick();
        set_lane(0, 3, 1'b1, 4, 1'b1, 1'b0, 'h73, 1'b0);
        push(0, 0, 'h73, 1'b0, "R9");
        tick(); clear_in(); tick(); tick();

        // R8: fill to 37 entries, check the stall threshold, then drain.
        for (int c = 0; c < 9; c++) begin
            check_bit(disp_ready, 1'b1, "R8 ready while filling");
            for (int k = 0; k < LANES; k++) begin
                set_lane(k, 90, 1'b0, 1, 1'b1, 1'b0, c*4 + k, 1'b0);
            end
            tick(); clear_in();
        end
        check_bit(disp_ready, 1'b1, "R8 ready with four free");
        set_lane(1, 90, 1'b0, 1, 1'b1, 1'b0, 36, 1'b0);
        tick(); clear_in();
        check_bit(disp_ready, 1'b0, "R8 stall with three free");
        for (int k = 0; k < LANES; k++) begin
            set_lane(k, 1, 1'b1, 1, 1'b1, 1'b0, 'hE0 + k, 1'b0);
        end
        tick();
        check_bit(disp_ready, 1'b0, "R8 stall holds, dispatch ignored");
        tick(); clear_in();
        for (int s = 0; s < 37; s++) begin
            push(s % 2, s, s, 1'b0, "R7");
        end
        wake(2, 90);
        tick(); clear_in();
        repeat (22) tick();
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R3: %0d expected issues missing, expected 0", exp_q.size());
        end
        check_bit(disp_ready, 1'b1, "R8 ready after drain");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule